// File: doc/BRIEF.md
# Threshold Programming Command Sequencer

This block listens to a two-wire serial bus and picks out one special write command. That command tells the analog side to commit a new trip threshold for one of three supervised supply channels. It samples the clock and data lines with the system clock and finds START, STOP and clock edges. It shifts in bytes MSB first on clock rising edges. It pulls the data line low during the ninth clock of every byte that matches the command pattern.

The command only counts if it meets four conditions, in this order:
- A high programming voltage is present on the watchdog output pin. The `hv_present_i` flag shows this, and it must already be high when the START arrives.
- The first byte is the device write address A0h.
- The second byte is a channel selector code.
- The third byte is 00h, and a STOP follows.

The STOP raises a one-hot program request for the chosen channel. That request stays up until the programming voltage is removed. A single-cycle completion pulse then follows. `hv_present_i` is treated as a signal that is already synchronous to `clk`. The bus lines pass through a parameterised synchronizer.

The control state machine has seven states:
- `ST_IDLE` goes to `ST_DEVADR` on a START while the flag is high.
- `ST_DEVADR` goes to `ST_REGADR` on an A0h byte.
- `ST_REGADR` goes to `ST_DATA` on a valid channel code.
- `ST_DATA` goes to `ST_ARMED` on a 00h byte.
- `ST_ARMED` goes to `ST_PROG` on a STOP.
- `ST_PROG` goes to `ST_DONE` when the flag falls.
- `ST_DONE` goes to `ST_IDLE` after one cycle.

In each of `ST_DEVADR`, `ST_REGADR`, `ST_DATA` and `ST_ARMED`, the block returns to `ST_IDLE` on any of the following:
- a mismatching byte
- a repeated START
- an early STOP
- loss of the flag

A further byte received in `ST_ARMED` also returns the block to `ST_IDLE`.

Top module: `thrprog_seq`

## Requirements
- R1: After reset the program request vector is all zero, the completion pulse is low, and the data line is not pulled.
- R2: A START detected while `hv_present_i` is low is ignored. The bytes that follow get no acknowledge, and the STOP raises no request even if the flag rises after the START.
- R3: The first byte after START must equal A0h (write address). Any other value gets no acknowledge, and the block returns to idle.
- R4: The second byte selects the channel. 01h sets request bit 0, 09h sets bit 1 and 0Dh sets bit 2. Any other value gets no acknowledge and raises no request.
- R5: The third byte must equal 00h. Any other value gets no acknowledge and raises no request.
- R6: For each matching byte (address, channel code, data), `sda_pull_o` is high while SCL is high during the ninth clock of that byte.
- R7: A STOP after a valid three-byte command raises exactly one request bit, for the selected channel. The bit stays stable while `hv_present_i` remains high.
- R8: When `hv_present_i` falls during a request, the request clears one cycle later. At the same time `prog_done_o` pulses high for exactly one cycle, and the block returns to idle.
- R9: A repeated START before the closing STOP aborts the pending command, and no request is raised.
- R10: While a request is active, bus traffic is ignored. No acknowledge is driven, and the request does not change.
- R11: If `hv_present_i` falls while a command is being received, the command is aborted, even if the flag rises again before the STOP.
- R12: A fourth byte received after a valid data byte and before STOP gets no acknowledge and cancels the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| hv_present_i | input | 1 | High programming voltage detected on the watchdog pin |
| sda_pull_o | output | 1 | High to pull the data line low (acknowledge) |
| prog_req_o | output | 3 | One-hot threshold program request, one bit per channel |
| prog_done_o | output | 1 | Single-cycle pulse when programming ends |

## Verification
The checker watches four properties on every cycle:
- the request vector never has more than one bit set;
- a request only rises after the flag was high;
- the request stays stable while the flag holds, and clears into a single-cycle completion pulse when the flag falls;
- no acknowledge is driven while a request is active.

The byte-level decoding can only be shown by the bench's directed bus transactions. This covers which address, channel and data values are accepted. It also covers where the acknowledge appears, how the block reacts to a repeated START, to an extra byte or to the flag dropping mid-command, and that a START without the flag is ignored.

// File: rtl/thrprog_pkg.sv
package thrprog_pkg;

    localparam int BYTE_W = 8;
    localparam int NUM_CH = 3;

    localparam logic [BYTE_W-1:0] DEV_WR_ADDR = 8'hA0;
    localparam logic [BYTE_W-1:0] COMMIT_DATA = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_REGADR,
        ST_DATA,
        ST_ARMED,
        ST_PROG,
        ST_DONE
    } seq_state_t;

    // Channel selector code for each monitored channel.
    function automatic logic [BYTE_W-1:0] chan_code(input int idx);
        logic [BYTE_W-1:0] code;
        case (idx)
            0:       code = 8'h01;
            1:       code = 8'h09;
            default: code = 8'h0D;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/thrprog_busmon.sv
module thrprog_busmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_q;
    logic                   sda_q;

    // Synchronizer chains; the first stage takes the pin, later stages follow.
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync[g] <= 1'b1;
                    sda_sync[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_sync[g] <= scl_i;
                    sda_sync[g] <= sda_i;
                end else begin
                    scl_sync[g] <= scl_sync[(g == 0) ? 0 : g - 1];
                    sda_sync[g] <= sda_sync[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_sync[LAST];
            sda_q <= sda_sync[LAST];
        end
    end

    always_comb begin
        sda_bit   = sda_sync[LAST];
        scl_rise  = !scl_q &&  scl_sync[LAST];
        scl_fall  =  scl_q && !scl_sync[LAST];
        // Data edges while the clock stays high mark bus conditions.
        start_det = scl_q && scl_sync[LAST] &&  sda_q && !sda_sync[LAST];
        stop_det  = scl_q && scl_sync[LAST] && !sda_q &&  sda_sync[LAST];
    end

endmodule

// File: rtl/thrprog_byterx.sv
module thrprog_byterx
    import thrprog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_bit,
    input  logic              ack_ok,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_val,
    output logic              sda_pull
);

    localparam int                CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              ack_phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            ack_phase <= 1'b0;
            sda_pull  <= 1'b0;
            byte_stb  <= 1'b0;
        end else if (start_det || stop_det || !enable) begin
            bit_cnt   <= '0;
            ack_phase <= 1'b0;
            sda_pull  <= 1'b0;
            byte_stb  <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            if (scl_rise && (bit_cnt < CNT_FULL)) begin
                shreg   <= {shreg[BYTE_W-2:0], sda_bit};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_LAST) begin
                    byte_stb <= 1'b1;
                end
            end
            if (scl_fall && (bit_cnt == CNT_FULL)) begin
                if (!ack_phase) begin
                    // Falling edge after the eighth bit: open the ninth clock.
                    ack_phase <= 1'b1;
                    sda_pull  <= ack_ok;
                end else begin
                    // Falling edge after the ninth clock: release the line.
                    ack_phase <= 1'b0;
                    sda_pull  <= 1'b0;
                    bit_cnt   <= '0;
                end
            end
        end
    end

    assign byte_val = shreg;

endmodule

// File: rtl/thrprog_cmdfsm.sv
module thrprog_cmdfsm
    import thrprog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_present,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_val,
    output logic              ack_ok,
    output logic              listen,
    output logic [NUM_CH-1:0] prog_req,
    output logic              prog_done
);

    seq_state_t        state_q, state_d;
    logic [NUM_CH-1:0] chan_q, chan_d;
    logic              ack_q, ack_d;
    logic [NUM_CH-1:0] chan_hit;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_hit
            assign chan_hit[g] = (byte_val == chan_code(g));
        end
    endgenerate

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        chan_d  = chan_q;
        ack_d   = ack_q;
        unique case (state_q)
            ST_IDLE: begin
                ack_d = 1'b0;
                if (start_det && hv_present) begin
                    state_d = ST_DEVADR;
                end
            end
            ST_DEVADR: begin
                if (!hv_present || start_det || stop_det) begin
                    state_d = ST_IDLE;
                    ack_d   = 1'b0;
                end else if (byte_stb) begin
                    if (byte_val == DEV_WR_ADDR) begin
                        state_d = ST_REGADR;
                        ack_d   = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                        ack_d   = 1'b0;
                    end
                end
            end
            ST_REGADR: begin
                if (!hv_present || start_det || stop_det) begin
                    state_d = ST_IDLE;
                    ack_d   = 1'b0;
                end else if (byte_stb) begin
                    if (|chan_hit) begin
                        state_d = ST_DATA;
                        chan_d  = chan_hit;
                        ack_d   = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                        ack_d   = 1'b0;
                    end
                end
            end
            ST_DATA: begin
                if (!hv_present || start_det || stop_det) begin
                    state_d = ST_IDLE;
                    ack_d   = 1'b0;
                end else if (byte_stb) begin
                    if (byte_val == COMMIT_DATA) begin
                        state_d = ST_ARMED;
                        ack_d   = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                        ack_d   = 1'b0;
                    end
                end
            end
            ST_ARMED: begin
                if (!hv_present || start_det) begin
                    state_d = ST_IDLE;
                    ack_d   = 1'b0;
                end else if (stop_det) begin
                    state_d = ST_PROG;
                    ack_d   = 1'b0;
                end else if (byte_stb) begin
                    state_d = ST_IDLE;
                    ack_d   = 1'b0;
                end
            end
            ST_PROG: begin
                ack_d = 1'b0;
                if (!hv_present) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                ack_d   = 1'b0;
                state_d = ST_IDLE;
            end
            default: begin
                ack_d   = 1'b0;
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chan_q  <= '0;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            chan_q  <= chan_d;
            ack_q   <= ack_d;
        end
    end

    // Moore outputs.
    always_comb begin
        ack_ok    = ack_q;
        listen    = (state_q == ST_DEVADR) || (state_q == ST_REGADR) ||
                    (state_q == ST_DATA)   || (state_q == ST_ARMED);
        prog_req  = (state_q == ST_PROG) ? chan_q : '0;
        prog_done = (state_q == ST_DONE);
    end

endmodule

// File: rtl/thrprog_seq.sv
module thrprog_seq
    import thrprog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              hv_present_i,
    output logic              sda_pull_o,
    output logic [NUM_CH-1:0] prog_req_o,
    output logic              prog_done_o
);

    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              sda_bit;
    logic              byte_stb;
    logic [BYTE_W-1:0] byte_val;
    logic              ack_ok;
    logic              listen;

    thrprog_busmon #(
        .SYNC_STAGES(SYNC_STAGES)
    ) busmon_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_bit  (sda_bit)
    );

    thrprog_byterx byterx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (listen),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_bit  (sda_bit),
        .ack_ok   (ack_ok),
        .byte_stb (byte_stb),
        .byte_val (byte_val),
        .sda_pull (sda_pull_o)
    );

    thrprog_cmdfsm cmdfsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hv_present(hv_present_i),
        .start_det (start_det),
        .stop_det  (stop_det),
        .byte_stb  (byte_stb),
        .byte_val  (byte_val),
        .ack_ok    (ack_ok),
        .listen    (listen),
        .prog_req  (prog_req_o),
        .prog_done (prog_done_o)
    );

endmodule

// File: rtl/thrprog_seq_chk.sv
module thrprog_seq_chk
    import thrprog_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              hv_present_i,
    input logic              sda_pull_o,
    input logic [NUM_CH-1:0] prog_req_o,
    input logic              prog_done_o
);

    // R7: never more than one channel requested.
    p_req_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prog_req_o));

    // R7: a request only begins after the flag was present.
    p_req_rise_hv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|prog_req_o) |-> $past(hv_present_i));

    // R7: request holds while the flag holds.
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|prog_req_o) && hv_present_i) |=> (prog_req_o == $past(prog_req_o)));

    // R8: flag removal clears the request into a completion pulse.
    p_done_after_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|prog_req_o) && !hv_present_i) |=> (prog_done_o && (prog_req_o == '0)));

    // R8: completion pulse lasts a single cycle.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done_o |=> !prog_done_o);

    // R10: no acknowledge while programming.
    p_no_ack_prog_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|prog_req_o) |-> !sda_pull_o);

endmodule

bind thrprog_seq thrprog_seq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .hv_present_i(hv_present_i),
    .sda_pull_o  (sda_pull_o),
    .prog_req_o  (prog_req_o),
    .prog_done_o (prog_done_o)
);

// File: tb/thrprog_seq_tb.sv
module thrprog_seq_tb_top;

    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic       hv = 1'b0;
    logic       sda_line;
    logic       sda_pull;
    logic [2:0] prog_req;
    logic       prog_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_drv & ~sda_pull;

    thrprog_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .hv_present_i(hv),
        .sda_pull_o  (sda_pull),
        .prog_req_o  (prog_req),
        .prog_done_o (prog_done)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wait_clk(HALF);
        scl = 1'b1;     wait_clk(HALF);
        sda_drv = 1'b0; wait_clk(HALF);
        scl = 1'b0;     wait_clk(HALF);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_clk(HALF);
        scl = 1'b1;     wait_clk(HALF);
        sda_drv = 1'b1; wait_clk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wait_clk(HALF);
            scl = 1'b1;     wait_clk(HALF);
            scl = 1'b0;
        end
        sda_drv = 1'b1; wait_clk(HALF);
        scl = 1'b1;     wait_clk(HALF / 2);
        acked = sda_pull;
        wait_clk(HALF - HALF / 2);
        scl = 1'b0;     wait_clk(HALF);
    endtask

    task automatic cleanup();
        hv = 1'b0;
        wait_clk(4);
    endtask

    task automatic cmd3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] d,
                        output logic [2:0] acks);
        bus_start();
        send_byte(a, acks[2]);
        send_byte(b, acks[1]);
        send_byte(d, acks[0]);
        bus_stop();
    endtask

    task automatic t_reset();
        check("R1 req", {5'd0, prog_req}, 8'h00);
        check("R1 done", {7'd0, prog_done}, 8'h00);
        check("R1 pull", {7'd0, sda_pull}, 8'h00);
    endtask

    task automatic t_valid(input logic [7:0] code, input logic [2:0] exp);
        logic [2:0] acks;
        hv = 1'b1; wait_clk(2);
        cmd3(8'hA0, code, 8'h00, acks);
        check("R6 acks", {5'd0, acks}, 8'h07);
        check("R4/R7 req", {5'd0, prog_req}, {5'd0, exp});
        wait_clk(20);
        check("R7 hold", {5'd0, prog_req}, {5'd0, exp});
        hv = 1'b0; wait_clk(1);
        check("R8 done", {7'd0, prog_done}, 8'h01);
        check("R8 req clear", {5'd0, prog_req}, 8'h00);
        wait_clk(1);
        check("R8 single pulse", {7'd0, prog_done}, 8'h00);
        wait_clk(4);
    endtask

    task automatic t_no_hv();
        logic [2:0] acks;
        hv = 1'b0; wait_clk(2);
        bus_start();
        hv = 1'b1;
        send_byte(8'hA0, acks[2]);
        send_byte(8'h01, acks[1]);
        send_byte(8'h00, acks[0]);
        bus_stop();
        check("R2 acks", {5'd0, acks}, 8'h00);
        check("R2 req", {5'd0, prog_req}, 8'h00);
        cleanup();
    endtask

    task automatic t_bad_addr(input logic [7:0] a);
        logic [2:0] acks;
        hv = 1'b1; wait_clk(2);
        cmd3(a, 8'h01, 8'h00, acks);
        check("R3 acks", {5'd0, acks}, 8'h00);
        check("R3 req", {5'd0, prog_req}, 8'h00);
        cleanup();
    endtask

    task automatic t_bad_chan();
        logic [2:0] acks;
        hv = 1'b1; wait_clk(2);
        cmd3(8'hA0, 8'h02, 8'h00, acks);
        check("R4 acks", {5'd0, acks}, 8'h04);
        check("R4 req", {5'd0, prog_req}, 8'h00);
        cleanup();
    endtask

    task automatic t_bad_data();
        logic [2:0] acks;
        hv = 1'b1; wait_clk(2);
        cmd3(8'hA0, 8'h09, 8'h01, acks);
        check("R5 acks", {5'd0, acks}, 8'h06);
        check("R5 req", {5'd0, prog_req}, 8'h00);
        cleanup();
    endtask

    task automatic t_restart();
        logic a0, a1, a2;
        hv = 1'b1; wait_clk(2);
        bus_start();
        send_byte(8'hA0, a0);
        send_byte(8'h01, a1);
        bus_start();
        send_byte(8'h00, a2);
        bus_stop();
        check("R9 data ack", {7'd0, a2}, 8'h00);
        check("R9 req", {5'd0, prog_req}, 8'h00);
        cleanup();
    endtask

    task automatic t_busy();
        logic [2:0] acks;
        hv = 1'b1; wait_clk(2);
        cmd3(8'hA0, 8'h01, 8'h00, acks);
        check("R10 entry", {5'd0, prog_req}, 8'h01);
        cmd3(8'hA0, 8'h0D, 8'h00, acks);
        check("R10 acks", {5'd0, acks}, 8'h00);
        check("R10 req", {5'd0, prog_req}, 8'h01);
        hv = 1'b0; wait_clk(1);
        check("R10 done", {7'd0, prog_done}, 8'h01);
        wait_clk(4);
    endtask

    task automatic t_hv_drop();
        logic a0, a1, a2;
        hv = 1'b1; wait_clk(2);
        bus_start();
        send_byte(8'hA0, a0);
        send_byte(8'h09, a1);
        hv = 1'b0; wait_clk(4);
        hv = 1'b1;
        send_byte(8'h00, a2);
        bus_stop();
        check("R11 data ack", {7'd0, a2}, 8'h00);
        check("R11 req", {5'd0, prog_req}, 8'h00);
        cleanup();
    endtask

    task automatic t_extra();
        logic a0, a1, a2, a3;
        hv = 1'b1; wait_clk(2);
        bus_start();
        send_byte(8'hA0, a0);
        send_byte(8'h0D, a1);
        send_byte(8'h00, a2);
        send_byte(8'h00, a3);
        bus_stop();
        check("R12 acks", {4'd0, a0, a1, a2, a3}, 8'h0E);
        check("R12 req", {5'd0, prog_req}, 8'h00);
        cleanup();
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_valid(8'h01, 3'b001);
        t_valid(8'h09, 3'b010);
        t_valid(8'h0D, 3'b100);
        t_no_hv();
        t_bad_addr(8'hA2);
        t_bad_addr(8'hA1);
        t_bad_chan();
        t_bad_data();
        t_restart();
        t_busy();
        t_hv_drop();
        t_extra();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule